// File: doc/BRIEF.md
# Shared-Bus Accumulator CPU Control Sequencer

This block is the control unit of a small 8-bit accumulator processor whose registers, memory, ALU and program counter all talk over one shared bus. It is a Moore state machine. After reset it idles for one cycle, then repeats a fetch/execute loop. Fetch always takes two cycles. Execute takes a short sequence of one to three cycles, and the sequence is chosen by the 4-bit operation code. In every state the block drives a set of strobes. The strobes name which unit drives the bus, which units capture it, and when the program counter steps, when the ALU subtracts, and when the machine stops.

The opcode input is the upper nibble of the word that the instruction register captures in the second fetch cycle. The datapath presents that nibble during that cycle, for example straight from the bus, and holds it for the rest of the instruction. The next state after fetch is decided from the value seen in the second fetch cycle.

Top module: `bus_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the controller enters an idle state with every strobe low. From that idle state it moves to the first fetch cycle at the next edge.
- R2: Fetch takes two cycles. First `pc_drive` and `mar_load` are high. Then `mem_drive`, `ir_load` and `pc_step` are high, and the opcode is decoded in that second cycle. Opcode values: 0000 no-op, 0001 load, 0010 add, 0011 subtract, 0100 store, 0101 load-immediate, 0110 jump, 1110 output, 1111 halt.
- R3: Load (0001) takes two cycles: `ir_drive`+`mar_load`, then `mem_drive`+`a_load`.
- R4: Add (0010) and subtract (0011) take three cycles: `ir_drive`+`mar_load`, then `mem_drive`+`b_load`, then `alu_drive`+`a_load`. `alu_sub` is high only in that last cycle and only for subtract.
- R5: Store (0100) takes two cycles: `ir_drive`+`mar_load`, then `a_drive`+`mem_write`.
- R6: Load-immediate (0101) takes one cycle with `ir_drive`+`a_load`. Output (1110) takes one cycle with `a_drive`+`out_load`.
- R7: Jump (0110) takes one cycle with `ir_drive`+`pc_load`, then one wait cycle with every strobe low, and then fetch restarts.
- R8: Halt (1111) reaches a state where only `halted` is high. The controller stays there whatever the opcode until reset.
- R9: No-op (0000) and the undefined opcodes 0111 to 1101 return straight to the first fetch cycle after the second fetch cycle. Every execute sequence also ends in the first fetch cycle.
- R10: At most one of `a_drive`, `b_drive`, `ir_drive`, `mem_drive`, `alu_drive`, `pc_drive` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 4 | Operation code, valid from the second fetch cycle |
| a_drive | output | 1 | Accumulator drives the bus |
| a_load | output | 1 | Accumulator captures the bus |
| b_drive | output | 1 | B register drives the bus |
| b_load | output | 1 | B register captures the bus |
| ir_drive | output | 1 | Instruction register low nibble drives the bus |
| ir_load | output | 1 | Instruction register captures the bus |
| mar_load | output | 1 | Memory address register captures the bus |
| mem_drive | output | 1 | Memory read data drives the bus |
| mem_write | output | 1 | Memory writes the bus value |
| alu_drive | output | 1 | ALU result drives the bus |
| alu_sub | output | 1 | ALU subtracts instead of adding |
| pc_drive | output | 1 | Program counter drives the bus |
| pc_load | output | 1 | Program counter captures the bus |
| pc_step | output | 1 | Program counter increments |
| out_load | output | 1 | Output register captures the bus |
| halted | output | 1 | Machine is stopped |

## Verification
The bench goes after the branch out of the second fetch cycle. That is where a decoder keyed to a stale opcode, or one that routes undefined codes anywhere but fetch, runs the wrong sequence. It checks that subtract alone raises the subtract select, and only in its third cycle, so a shared add/subtract path that leaks the flag gets caught. It checks that jump spends its quiet wait cycle, and that halt ignores later opcode changes and leaves only through reset. Reset is also applied in the middle of an add to show the idle cycle comes back with every strobe low.

// File: rtl/cpu_seq_pkg.sv
// Package: shared types for the bus CPU control sequencer.
// Assumes a 4-bit opcode and a single shared bus.
package cpu_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NOP  = 4'b0000;
    localparam logic [OP_W-1:0] OP_LDA  = 4'b0001;
    localparam logic [OP_W-1:0] OP_ADD  = 4'b0010;
    localparam logic [OP_W-1:0] OP_SUB  = 4'b0011;
    localparam logic [OP_W-1:0] OP_STA  = 4'b0100;
    localparam logic [OP_W-1:0] OP_LDI  = 4'b0101;
    localparam logic [OP_W-1:0] OP_JMP  = 4'b0110;
    localparam logic [OP_W-1:0] OP_OUT  = 4'b1110;
    localparam logic [OP_W-1:0] OP_HALT = 4'b1111;

    localparam int ST_W = 5;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE,
        ST_FETCH_ADDR,
        ST_FETCH_WORD,
        ST_LD_ADDR,
        ST_LD_READ,
        ST_ADD_ADDR,
        ST_ADD_READ,
        ST_ADD_SUM,
        ST_SUB_ADDR,
        ST_SUB_READ,
        ST_SUB_DIFF,
        ST_ST_ADDR,
        ST_ST_WRITE,
        ST_IMM_LOAD,
        ST_JMP_LOAD,
        ST_JMP_WAIT,
        ST_OUT_LOAD,
        ST_STOP
    } seq_state_t;

    typedef struct packed {
        logic a_drive;
        logic a_load;
        logic b_drive;
        logic b_load;
        logic ir_drive;
        logic ir_load;
        logic mar_load;
        logic mem_drive;
        logic mem_write;
        logic alu_drive;
        logic alu_sub;
        logic pc_drive;
        logic pc_load;
        logic pc_step;
        logic out_load;
        logic halted;
    } strobe_t;

endpackage

// File: rtl/seq_state_reg.sv
// Module: state register of the sequencer.
// Holds the current state and loads the idle state on a synchronous active-low reset.
module seq_state_reg
    import cpu_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t nxt,
    output seq_state_t cur
);

    // Purpose: capture the next state, or force idle during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

endmodule

// File: rtl/seq_next_state.sv
// Module: next-state logic of the sequencer.
// Assumes the opcode is valid during the second fetch cycle; decodes it only there.
module seq_next_state
    import cpu_seq_pkg::*;
(
    input  seq_state_t      cur,
    input  logic [OP_W-1:0] opcode,
    output seq_state_t      nxt
);

    seq_state_t dispatch;

    // Purpose: choose the first execute state from the opcode.
    always_comb begin
        unique case (opcode)
            OP_LDA:  dispatch = ST_LD_ADDR;
            OP_ADD:  dispatch = ST_ADD_ADDR;
            OP_SUB:  dispatch = ST_SUB_ADDR;
            OP_STA:  dispatch = ST_ST_ADDR;
            OP_LDI:  dispatch = ST_IMM_LOAD;
            OP_JMP:  dispatch = ST_JMP_LOAD;
            OP_OUT:  dispatch = ST_OUT_LOAD;
            OP_HALT: dispatch = ST_STOP;
            default: dispatch = ST_FETCH_ADDR;
        endcase
    end

    // Purpose: step through the fixed fetch and execute sequences.
    always_comb begin
        unique case (cur)
            ST_IDLE:       nxt = ST_FETCH_ADDR;
            ST_FETCH_ADDR: nxt = ST_FETCH_WORD;
            ST_FETCH_WORD: nxt = dispatch;
            ST_LD_ADDR:    nxt = ST_LD_READ;
            ST_ADD_ADDR:   nxt = ST_ADD_READ;
            ST_ADD_READ:   nxt = ST_ADD_SUM;
            ST_SUB_ADDR:   nxt = ST_SUB_READ;
            ST_SUB_READ:   nxt = ST_SUB_DIFF;
            ST_ST_ADDR:    nxt = ST_ST_WRITE;
            ST_JMP_LOAD:   nxt = ST_JMP_WAIT;
            ST_STOP:       nxt = ST_STOP;
            default:       nxt = ST_FETCH_ADDR;
        endcase
    end

endmodule

// File: rtl/seq_strobe_decode.sv
// Module: output decoder of the sequencer.
// Moore outputs: the strobes depend only on the current state.
module seq_strobe_decode
    import cpu_seq_pkg::*;
(
    input  seq_state_t cur,
    output strobe_t    stb
);

    // Purpose: raise the bus source, the bus sinks and the side strobes for each state.
    always_comb begin
        stb = '0;
        unique case (cur)
            ST_FETCH_ADDR: begin stb.pc_drive  = 1'b1; stb.mar_load = 1'b1; end
            ST_FETCH_WORD: begin
                stb.mem_drive = 1'b1; stb.ir_load = 1'b1; stb.pc_step = 1'b1;
            end
            ST_LD_ADDR,
            ST_ADD_ADDR,
            ST_SUB_ADDR,
            ST_ST_ADDR:    begin stb.ir_drive  = 1'b1; stb.mar_load  = 1'b1; end
            ST_LD_READ:    begin stb.mem_drive = 1'b1; stb.a_load    = 1'b1; end
            ST_ADD_READ,
            ST_SUB_READ:   begin stb.mem_drive = 1'b1; stb.b_load    = 1'b1; end
            ST_ADD_SUM:    begin stb.alu_drive = 1'b1; stb.a_load    = 1'b1; end
            ST_SUB_DIFF:   begin
                stb.alu_drive = 1'b1; stb.a_load = 1'b1; stb.alu_sub = 1'b1;
            end
            ST_ST_WRITE:   begin stb.a_drive   = 1'b1; stb.mem_write = 1'b1; end
            ST_IMM_LOAD:   begin stb.ir_drive  = 1'b1; stb.a_load    = 1'b1; end
            ST_JMP_LOAD:   begin stb.ir_drive  = 1'b1; stb.pc_load   = 1'b1; end
            ST_OUT_LOAD:   begin stb.a_drive   = 1'b1; stb.out_load  = 1'b1; end
            ST_STOP:       stb.halted = 1'b1;
            default:       stb = '0;
        endcase
    end

endmodule

// File: rtl/bus_seq_ctrl.sv
// Module: top of the shared-bus CPU control sequencer.
// Wires the state register, the next-state logic and the strobe decoder.
// Assumes opcode is valid from the second fetch cycle to the end of the instruction.
module bus_seq_ctrl
    import cpu_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic            a_drive,
    output logic            a_load,
    output logic            b_drive,
    output logic            b_load,
    output logic            ir_drive,
    output logic            ir_load,
    output logic            mar_load,
    output logic            mem_drive,
    output logic            mem_write,
    output logic            alu_drive,
    output logic            alu_sub,
    output logic            pc_drive,
    output logic            pc_load,
    output logic            pc_step,
    output logic            out_load,
    output logic            halted
);

    seq_state_t cur_st;
    seq_state_t nxt_st;
    strobe_t    stb;

    seq_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt_st),
        .cur   (cur_st)
    );

    seq_next_state u_next (
        .cur    (cur_st),
        .opcode (opcode),
        .nxt    (nxt_st)
    );

    seq_strobe_decode u_dec (
        .cur (cur_st),
        .stb (stb)
    );

    assign a_drive   = stb.a_drive;
    assign a_load    = stb.a_load;
    assign b_drive   = stb.b_drive;
    assign b_load    = stb.b_load;
    assign ir_drive  = stb.ir_drive;
    assign ir_load   = stb.ir_load;
    assign mar_load  = stb.mar_load;
    assign mem_drive = stb.mem_drive;
    assign mem_write = stb.mem_write;
    assign alu_drive = stb.alu_drive;
    assign alu_sub   = stb.alu_sub;
    assign pc_drive  = stb.pc_drive;
    assign pc_load   = stb.pc_load;
    assign pc_step   = stb.pc_step;
    assign out_load  = stb.out_load;
    assign halted    = stb.halted;

endmodule

// File: rtl/bus_seq_ctrl_chk.sv
// Module: property checker for bus_seq_ctrl, attached through bind.
// Watches the top-level ports only.
module bus_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic a_drive,
    input logic a_load,
    input logic b_drive,
    input logic b_load,
    input logic ir_drive,
    input logic ir_load,
    input logic mar_load,
    input logic mem_drive,
    input logic mem_write,
    input logic alu_drive,
    input logic alu_sub,
    input logic pc_drive,
    input logic pc_load,
    input logic pc_step,
    input logic out_load,
    input logic halted
);

    logic was_rst = 1'b0;
    logic any_stb;

    assign any_stb = a_drive | a_load | b_drive | b_load | ir_drive | ir_load |
                     mar_load | mem_drive | mem_write | alu_drive | alu_sub |
                     pc_drive | pc_load | pc_step | out_load | halted;

    // Purpose: remember that reset was applied at the previous edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> !any_stb);

    p_idle_to_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |=> (pc_drive && mar_load));

    p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_drive |=> (mem_drive && ir_load && pc_step));

    p_sub_last_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alu_sub |-> (alu_drive && a_load && $past(b_load)));

    p_jump_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !any_stb);

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_drive, b_drive, ir_drive, mem_drive, alu_drive, pc_drive}) <= 1);

endmodule

bind bus_seq_ctrl bus_seq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_drive   (a_drive),
    .a_load    (a_load),
    .b_drive   (b_drive),
    .b_load    (b_load),
    .ir_drive  (ir_drive),
    .ir_load   (ir_load),
    .mar_load  (mar_load),
    .mem_drive (mem_drive),
    .mem_write (mem_write),
    .alu_drive (alu_drive),
    .alu_sub   (alu_sub),
    .pc_drive  (pc_drive),
    .pc_load   (pc_load),
    .pc_step   (pc_step),
    .out_load  (out_load),
    .halted    (halted)
);

// File: tb/bus_seq_ctrl_test.sv
`timescale 1ns/100ps
// Bench: scoreboard for bus_seq_ctrl. A driver pushes the expected strobe
// vector of every cycle; a monitor compares at each falling edge.
module bus_seq_ctrl_test;

    // Bench vector order, msb first:
    // a_drive a_load b_drive b_load ir_drive ir_load mar_load mem_drive
    // mem_write alu_drive alu_sub pc_drive pc_load pc_step out_load halted
    localparam logic [15:0] M_AD = 16'h8000, M_AL = 16'h4000, M_BD = 16'h2000, M_BL = 16'h1000;
    localparam logic [15:0] M_ID = 16'h0800, M_IL = 16'h0400, M_ML = 16'h0200, M_RD = 16'h0100;
    localparam logic [15:0] M_RW = 16'h0080, M_UD = 16'h0040, M_US = 16'h0020, M_PD = 16'h0010;
    localparam logic [15:0] M_PL = 16'h0008, M_PS = 16'h0004, M_OL = 16'h0002, M_HT = 16'h0001;
    localparam logic [15:0] DRV  = M_AD | M_BD | M_ID | M_RD | M_UD | M_PD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opcode = 4'b0000;
    logic a_drive, a_load, b_drive, b_load, ir_drive, ir_load, mar_load, mem_drive;
    logic mem_write, alu_drive, alu_sub, pc_drive, pc_load, pc_step, out_load, halted;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    bus_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .a_drive(a_drive), .a_load(a_load), .b_drive(b_drive), .b_load(b_load),
        .ir_drive(ir_drive), .ir_load(ir_load), .mar_load(mar_load), .mem_drive(mem_drive),
        .mem_write(mem_write), .alu_drive(alu_drive), .alu_sub(alu_sub), .pc_drive(pc_drive),
        .pc_load(pc_load), .pc_step(pc_step), .out_load(out_load), .halted(halted)
    );

    function automatic logic [15:0] observed();
        return {a_drive, a_load, b_drive, b_load, ir_drive, ir_load, mar_load, mem_drive,
                mem_write, alu_drive, alu_sub, pc_drive, pc_load, pc_step, out_load, halted};
    endfunction

    task automatic push(input logic [15:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Driver: queue fetch plus the execute vectors, present the opcode, wait them out.
    task automatic run_op(input logic [3:0] op, input string tag);
        int n;
        push(M_PD | M_ML, "R2 fetch-addr");
        push(M_RD | M_IL | M_PS, "R2 fetch-word");
        n = 2;
        case (op)
            4'b0001: begin push(M_ID | M_ML, tag); push(M_RD | M_AL, tag); n += 2; end
            4'b0010: begin
                push(M_ID | M_ML, tag); push(M_RD | M_BL, tag); push(M_UD | M_AL, tag); n += 3;
            end
            4'b0011: begin
                push(M_ID | M_ML, tag); push(M_RD | M_BL, tag);
                push(M_UD | M_AL | M_US, tag); n += 3;
            end
            4'b0100: begin push(M_ID | M_ML, tag); push(M_AD | M_RW, tag); n += 2; end
            4'b0101: begin push(M_ID | M_AL, tag); n += 1; end
            4'b0110: begin push(M_ID | M_PL, tag); push(16'h0000, tag); n += 2; end
            4'b1110: begin push(M_AD | M_OL, tag); n += 1; end
            default: ;
        endcase
        opcode = op;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: pop and compare one expected vector per cycle, plus the single-driver rule.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [15:0] e, o;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            o = observed();
            checks++;
            if (o !== e) begin
                errors++;
                $display("FAIL %s: strobes actual=%b expected=%b", t, o, e);
            end
            checks++;
            if ($countones(o & DRV) > 1) begin
                errors++;
                $display("FAIL R10: bus drivers actual=%b expected at most one", o & DRV);
            end
        end
    end

    task automatic direct_check(input logic [15:0] e, input string tag);
        checks++;
        if (observed() !== e) begin
            errors++;
            $display("FAIL %s: strobes actual=%b expected=%b", tag, observed(), e);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1: reset state all quiet
        repeat (3) @(posedge clk);
        #1 direct_check(16'h0000, "R1 idle");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        run_op(4'b0001, "R3 load");
        run_op(4'b0010, "R4 add");
        run_op(4'b0011, "R4 sub");
        run_op(4'b0100, "R5 store");
        run_op(4'b0101, "R6 load-imm");
        run_op(4'b0110, "R7 jump");
        run_op(4'b1110, "R6 output");
        run_op(4'b0000, "R9 nop");
        run_op(4'b0111, "R9 undef 0111");
        run_op(4'b1010, "R9 undef 1010");
        run_op(4'b1101, "R9 undef 1101");
        run_op(4'b0011, "R4 sub again");
        run_op(4'b0010, "R4 add after sub");

        // R1: reset in the middle of an add
        push(M_PD | M_ML, "R2 fetch-addr");
        push(M_RD | M_IL | M_PS, "R2 fetch-word");
        push(M_ID | M_ML, "R4 add");
        opcode = 4'b0010;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1 direct_check(16'h0000, "R1 mid-add reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        run_op(4'b0101, "R1 restart load-imm");

        // R8: halt ignores later opcodes
        push(M_PD | M_ML, "R2 fetch-addr");
        push(M_RD | M_IL | M_PS, "R2 fetch-word");
        for (int i = 0; i < 6; i++) push(M_HT, "R8 halt");
        opcode = 4'b1111;
        repeat (3) @(posedge clk);
        opcode = 4'b0001; @(posedge clk);
        opcode = 4'b0110; @(posedge clk);
        opcode = 4'b0000; @(posedge clk);
        opcode = 4'b0101; @(posedge clk);
        opcode = 4'b0010; @(posedge clk);
        #1;
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1 direct_check(16'h0000, "R8 reset leaves halt");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        run_op(4'b1110, "R8 resume output");
        run_op(4'b0110, "R7 jump after resume");

        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: queue actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule